// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Sticky Overflow Flag

This block is an up-counter with a sticky overflow flag and a maskable interrupt output. It has two count sources. In cycle mode it counts the instruction-cycle strobe. In pin mode it counts one chosen edge of an external clock pin. The pin is first sampled on the internal phase strobes and passed through a short synchronizer chain. A previous-sample comparison then turns each edge into a single count.

Software can load the count at any time through a write port. A load holds counting off for the next two instruction cycles, and counting then continues from the loaded value. When the count wraps from all ones to zero, the flag is set. It stays set until software clears it. The interrupt output is the flag gated by an enable bit. While the sleep input is high the counter is frozen, so no wrap and no interrupt can occur.

Top module: `tmc_timer`

## Requirements
- R1: After reset the count reads 8'h00, the overflow flag is 0 and the interrupt output is 0.
- R2: With src_sel = 0 the count rises by exactly one in each clock in which cyc_en is 1, and it holds in every other clock.
- R3: With src_sel = 1 and edge_sel = 0, each rising edge of ext_clk adds exactly one to the count, falling edges add nothing, and cyc_en does not advance the count.
- R4: With src_sel = 1 and edge_sel = 1, each falling edge of ext_clk adds exactly one to the count, and rising edges add nothing.
- R5: A clock with wr_en = 1 loads wr_data into the count. The first two cyc_en pulses after the load produce no increment, and the third pulse increments again.
- R6: An increment from 8'hFF to 8'h00 sets ovf_flag. The flag then stays 1 until a clock with flag_clr = 1 and no new wrap.
- R7: irq is 1 exactly when ovf_flag is 1 and irq_en is 1.
- R8: While sleep = 1 the count does not change except by a write, and ovf_flag cannot become set.
- R9: When a write and a wrap-causing increment fall in the same clock, the written value is loaded and ovf_flag is not set by that clock.
- R10: When flag_clr and a wrap fall in the same clock, ovf_flag ends up 1.
- R11: ext_clk is seen only in clocks with smp_en = 1. A level that is held across at least one sampling clock is counted. A pulse that starts and ends between sampling clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle strobe, one clock per instruction cycle |
| smp_en | input | 1 | Phase sampling strobe for the external pin |
| src_sel | input | 1 | Count source: 0 selects the cycle strobe, 1 selects the pin |
| edge_sel | input | 1 | Pin edge: 0 selects rising, 1 selects falling |
| ext_clk | input | 1 | External count pin |
| wr_en | input | 1 | Count load strobe |
| wr_data | input | 8 | Value to load |
| rd_data | output | 8 | Current count |
| irq_en | input | 1 | Interrupt enable |
| sleep | input | 1 | Freezes counting while high |
| flag_clr | input | 1 | Software clear of the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The properties assume that ext_clk changes only between clock edges. They also assume that rst_n is released in step with clk, so a write in the first clock after reset is a real load. The stimulus drives every input one time unit after a rising edge. It keeps pin levels steady over several sampling strobes, except in the one case that checks pulse rejection. The bench also holds wr_en low whenever it relies on the unit-step property.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic {
    SRC_CYCLE = 1'b0,
    SRC_PIN   = 1'b1
  } src_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

  localparam int unsigned DEF_WIDTH       = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_HOLD_CYC    = 2;
endpackage

// File: rtl/tmc_pin_sync.sv
// Samples the external pin on phase strobes, synchronizes it and
// produces a one-clock pulse per selected edge.
module tmc_pin_sync #(
  parameter int unsigned SYNC_STAGES = tmc_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic pin,
  input  logic edge_sel,
  output logic edge_pulse
);
  import tmc_pkg::*;

  logic [SYNC_STAGES-1:0] chain_q, chain_d;
  logic                   prev_q, prev_d;
  logic                   cur;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_comb chain_d = smp_en ? pin : chain_q;
    end else begin : g_multi
      always_comb chain_d = smp_en ? {chain_q[SYNC_STAGES-2:0], pin} : chain_q;
    end
  endgenerate

  assign cur = chain_q[SYNC_STAGES-1];

  always_comb begin
    prev_d = smp_en ? cur : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  always_comb begin
    if (edge_e'(edge_sel) == EDGE_FALL) edge_pulse = smp_en & prev_q & ~cur;
    else                                edge_pulse = smp_en & cur & ~prev_q;
  end
endmodule

// File: rtl/tmc_hold.sv
// Post-write inhibit window measured in instruction cycles.
module tmc_hold #(
  parameter int unsigned HOLD_CYC = tmc_pkg::DEF_HOLD_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic busy
);
  localparam int unsigned HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);

  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                       cnt_d = HW'(HOLD_CYC);
    else if (step && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/tmc_count.sv
// Loadable up-counter with a wrap indication.
module tmc_count #(
  parameter int unsigned WIDTH = tmc_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] value,
  output logic             wrap
);
  logic [WIDTH-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (load)     val_d = load_val;
    else if (inc) val_d = val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign value = val_q;
  assign wrap  = inc & ~load & (&val_q);
endmodule

// File: rtl/tmc_timer.sv
// Timer/counter top: source select, post-write inhibit, sleep gating,
// sticky overflow flag and masked interrupt.
module tmc_timer #(
  parameter int unsigned WIDTH       = tmc_pkg::DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = tmc_pkg::DEF_SYNC_STAGES,
  parameter int unsigned HOLD_CYC    = tmc_pkg::DEF_HOLD_CYC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             smp_en,
  input  logic             src_sel,
  input  logic             edge_sel,
  input  logic             ext_clk,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic             irq_en,
  input  logic             sleep,
  input  logic             flag_clr,
  output logic             ovf_flag,
  output logic             irq
);
  import tmc_pkg::*;

  logic pin_edge;
  logic hold_busy;
  logic tick;
  logic inc;
  logic wrap;
  logic flag_q, flag_d;

  tmc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (smp_en),
    .pin       (ext_clk),
    .edge_sel  (edge_sel),
    .edge_pulse(pin_edge)
  );

  tmc_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wr_en),
    .step (cyc_en & ~sleep),
    .busy (hold_busy)
  );

  always_comb begin
    tick = (src_e'(src_sel) == SRC_PIN) ? pin_edge : cyc_en;
    inc  = tick & ~sleep & ~hold_busy & ~wr_en;
  end

  tmc_count #(.WIDTH(WIDTH)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (inc),
    .load    (wr_en),
    .load_val(wr_data),
    .value   (rd_data),
    .wrap    (wrap)
  );

  // A wrap outranks a software clear so the event is never lost.
  always_comb begin
    flag_d = flag_q;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign ovf_flag = flag_q;
  assign irq      = flag_q & irq_en;
endmodule

// File: rtl/tmc_timer_chk.sv
module tmc_timer_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic             sleep,
  input logic             flag_clr,
  input logic             ovf_flag,
  input logic             hold_busy
);
  // R5: a write is visible in the next clock
  a_r5_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data)));

  // R5: no count change while the inhibit window is open
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_busy && !wr_en) |=> $stable(rd_data));

  // R2: without a write the count moves by at most one
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rd_data == $past(rd_data) || rd_data == WIDTH'($past(rd_data) + 1'b1)));

  // R8: sleep freezes the count
  a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wr_en) |=> $stable(rd_data));

  // R8: no new flag during sleep
  a_r8_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !ovf_flag) |=> !ovf_flag);

  // R6: flag holds until cleared
  a_r6_flag_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  // R6: flag rises only on an all-ones to zero step
  a_r6_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(rd_data) == '1 && rd_data == '0));

  // R9: a write clock never raises the flag
  a_r9_write_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ovf_flag) |=> !ovf_flag);
endmodule

bind tmc_timer tmc_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .sleep    (sleep),
  .flag_clr (flag_clr),
  .ovf_flag (ovf_flag),
  .hold_busy(hold_busy)
);

// File: tb/tmc_timer_tb.sv
module tmc_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_en, smp_en, src_sel, edge_sel, ext_clk;
  logic       wr_en, irq_en, sleep, flag_clr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       ovf_flag, irq;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  int expc;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmc_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .smp_en(smp_en),
    .src_sel(src_sel), .edge_sel(edge_sel), .ext_clk(ext_clk),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_en(irq_en), .sleep(sleep), .flag_clr(flag_clr),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // one clock of the phase pattern: sample strobes at phases 1 and 3,
  // instruction-cycle strobe at phase 3
  task automatic pstep();
    smp_en = (ph == 1) || (ph == 3);
    cyc_en = (ph == 3);
    step();
    ph = (ph + 1) % 4;
  endtask

  task automatic prun(input int n);
    for (int i = 0; i < n; i++) pstep();
  endtask

  task automatic write(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v; cyc_en = 1'b0; smp_en = 1'b0;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_en = 0; smp_en = 0; src_sel = 0; edge_sel = 0;
    ext_clk = 0; wr_en = 0; wr_data = 0; irq_en = 0; sleep = 0; flag_clr = 0;
    repeat (3) step();
    chk("R1 count", rd_data, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    step();

    // R2: cycle mode, irregular strobe pattern
    expc = 0;
    for (int i = 0; i < 40; i++) begin
      cyc_en = (((i * 7) % 5) < 3);
      step();
      if (cyc_en) expc++;
      chk("R2 count", rd_data, expc);
    end
    cyc_en = 0;

    // R5/R6: exhaustive load values, inhibit of two cycles then one step
    for (int v = 0; v < 256; v++) begin
      wr_en = 1; wr_data = 8'(v); flag_clr = 1; cyc_en = 0;
      step();
      wr_en = 0; flag_clr = 0;
      chk("R5 load", rd_data, v);
      cyc_en = 1;
      step(); chk("R5 inhibit1", rd_data, v);
      step(); chk("R5 inhibit2", rd_data, v);
      step(); chk("R5 resume", rd_data, (v + 1) % 256);
      chk("R6 wrap flag", ovf_flag, (v == 255) ? 1 : 0);
      cyc_en = 0;
    end

    // R6/R7: flag sticks, gated interrupt, clear
    repeat (5) step();
    chk("R6 sticky", ovf_flag, 1);
    irq_en = 0; #1; chk("R7 masked", irq, 0);
    irq_en = 1; #1; chk("R7 enabled", irq, 1);
    flag_clr = 1; step(); flag_clr = 0;
    chk("R6 cleared", ovf_flag, 0);
    chk("R7 irq after clear", irq, 0);

    // R8: sleep at FF with window expired
    write(8'hFF);
    cyc_en = 1; step(); step(); cyc_en = 0;
    sleep = 1; cyc_en = 1;
    repeat (10) step();
    chk("R8 count frozen", rd_data, 8'hFF);
    chk("R8 no flag", ovf_flag, 0);
    chk("R8 no irq", irq, 0);
    sleep = 0; step(); cyc_en = 0;
    chk("R8 resume wrap", rd_data, 0);
    chk("R8 resume flag", ovf_flag, 1);

    // R10: clear coinciding with a wrap keeps the flag
    write(8'hFF);
    cyc_en = 1; step(); step();
    flag_clr = 1; step(); flag_clr = 0; cyc_en = 0;
    chk("R10 count", rd_data, 0);
    chk("R10 flag kept", ovf_flag, 1);

    // R9: write coinciding with a wrap wins
    flag_clr = 1; step(); flag_clr = 0;
    write(8'hFF);
    cyc_en = 1; step(); step();
    wr_en = 1; wr_data = 8'h10; step(); wr_en = 0; cyc_en = 0;
    chk("R9 count", rd_data, 8'h10);
    chk("R9 flag", ovf_flag, 0);
    irq_en = 0;

    // R3/R4: pin mode, both edges, several pulse counts
    src_sel = 1;
    for (int es = 0; es < 2; es++) begin
      for (int n = 1; n <= 6; n++) begin
        edge_sel = es[0];
        ext_clk = es[0];          // idle level opposite to the counted edge
        prun(16);
        write(8'h00);
        prun(16);
        chk(es ? "R4 idle" : "R3 idle", rd_data, 0);
        for (int k = 1; k <= n; k++) begin
          ext_clk = ~ext_clk; prun(8);
          chk(es ? "R4 counted edge" : "R3 counted edge", rd_data, k);
          ext_clk = ~ext_clk; prun(8);
          chk(es ? "R4 other edge" : "R3 other edge", rd_data, k);
        end
        prun(16);
        chk(es ? "R4 total" : "R3 total cyc ignored", rd_data, n);
      end
    end

    // R11: pulse between strobes is missed, pulse on a strobe is kept
    edge_sel = 0; ext_clk = 0;
    prun(16);
    write(8'h20);
    prun(16);
    while (ph != 0) pstep();
    ext_clk = 1; pstep(); ext_clk = 0;
    prun(16);
    chk("R11 short pulse ignored", rd_data, 8'h20);
    while (ph != 1) pstep();
    ext_clk = 1; pstep(); ext_clk = 0;
    prun(16);
    chk("R11 sampled pulse counted", rd_data, 8'h21);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule